// File: doc/BRIEF.md
# Receive Count Snapshot on Slave Deselect

This block sits beside a ping-pong receive DMA of an SPI slave. The DMA has two buffers, A and B, and each keeps a running byte count. When the master releases the slave select line, software needs to know how many bytes arrived in the buffer that was filling at that moment. The block takes the count of the active buffer when the select line goes from low to high and holds it in a saved-count register.

A capture is armed by loading a buffer. The first deselect edge after a load takes the snapshot and disarms the capture. Any later deselect edge leaves the snapshot alone and sets a flag that reports the extra edge. A 3-bit status field shows which buffer the snapshot came from and whether an extra edge was seen. A clear strobe zeroes the status field. The select line is asynchronous and passes through a two-flop synchronizer before edge detection. The memory transfer engine is not part of this block.

Top module: `rxsnap_top`

## Requirements
- R1: A low-to-high transition of `sel_n_i` copies the count of the active buffer into `saved_cnt_o` when the capture is armed. `active_b_i`=0 selects `cnt_a_i` and 1 selects `cnt_b_i`. The counts are sampled on the third rising clock edge after the input changes (two synchronizer flops plus the capture register), and the result is visible after that edge.
- R2: Once a capture has happened, later rising select edges leave `saved_cnt_o` unchanged until a buffer is loaded again.
- R3: A rising select edge that arrives while the capture is not armed sets status bit 2 (extra edge). Bits 1:0 and `saved_cnt_o` keep their values.
- R4: Status encoding: bit0 = snapshot taken from buffer A, bit1 = snapshot taken from buffer B, bit2 = extra edge seen. A capture writes bits 1:0 to match the buffer it used and clears bit 2. Bits 1:0 are never both set.
- R5: A one-cycle pulse on `load_a_i` or `load_b_i` re-arms the capture. The load itself changes neither output.
- R6: A one-cycle pulse on `stat_clr_i` zeroes all three status bits and leaves `saved_cnt_o` unchanged. When a capture or an extra edge lands in the same cycle as the clear, the event's update wins.
- R7: After synchronous reset, `saved_cnt_o` is 0, the status is 0 and the capture is disarmed. A deselect edge before any load therefore sets only bit 2.
- R8: A load that coincides with a capture lets that capture happen and leaves the capture armed, so the next deselect edge captures again.
- R9: A high-to-low transition of `sel_n_i` (the slave being selected) changes neither output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_n_i | input | 1 | Asynchronous active-low slave select |
| load_a_i | input | 1 | Buffer A loaded (one-cycle pulse) |
| load_b_i | input | 1 | Buffer B loaded (one-cycle pulse) |
| active_b_i | input | 1 | Active receive buffer: 0 = A, 1 = B |
| cnt_a_i | input | CNT_W | Running byte count of buffer A |
| cnt_b_i | input | CNT_W | Running byte count of buffer B |
| stat_clr_i | input | 1 | Clear the status field (one-cycle pulse) |
| saved_cnt_o | output | CNT_W | Count captured on deselect |
| stat_o | output | 3 | Snapshot status: {extra edge, from B, from A} |

## Verification
On every cycle, the assertions check the following rules. The snapshot may change only in the cycle after a capture pulse. A load always leaves the capture armed. A capture without a load disarms it. The two source bits never show both buffers. A clear with no edge empties the status field. An unarmed edge raises the extra-edge flag. Other behaviour only shows up in the bench's scenarios. This covers the three-cycle latency from the select pin, which buffer's count ends up in the snapshot, the order of status values across load, multi-edge and clear sequences, a load landing on the capture edge, and the select-assert edge having no effect.

// File: rtl/rxsnap_pkg.sv
package rxsnap_pkg;
  localparam int STAT_W = 3;
  typedef enum int {
    ST_FROM_A = 0,
    ST_FROM_B = 1,
    ST_EXTRA  = 2
  } stat_bit_e;
  typedef logic [STAT_W-1:0] stat_t;
endpackage

// File: rtl/rxsnap_sync.sv
module rxsnap_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o,
  output logic rise_o
);
  localparam int DEPTH = STAGES + 1;
  logic [DEPTH-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= {DEPTH{RST_VAL}};
    else     pipe <= {pipe[DEPTH-2:0], d_i};
  end

  // pipe[STAGES-1] is the synchronized level; pipe[STAGES] is its previous value
  assign q_o    = pipe[STAGES-1];
  assign rise_o = pipe[STAGES-1] & ~pipe[STAGES];
endmodule

// File: rtl/rxsnap_arm.sv
module rxsnap_arm #(
  parameter int NBUF = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rise_i,
  input  logic [NBUF-1:0] load_i,
  output logic            armed_o,
  output logic            cap_o,
  output logic            extra_o
);
  logic armed_q;
  logic any_load;

  assign any_load = |load_i;

  always_ff @(posedge clk) begin
    if (rst)           armed_q <= 1'b0;
    else if (any_load) armed_q <= 1'b1;
    else if (rise_i)   armed_q <= 1'b0;
  end

  assign armed_o = armed_q;
  assign cap_o   = rise_i & armed_q;
  assign extra_o = rise_i & ~armed_q;
endmodule

// File: rtl/rxsnap_status.sv
module rxsnap_status
  import rxsnap_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  cap_i,
  input  logic  extra_i,
  input  logic  take_b_i,
  input  logic  clr_i,
  output stat_t stat_o
);
  stat_t stat_q;
  stat_t base;

  always_comb begin
    base = clr_i ? '0 : stat_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
    end else if (cap_i) begin
      stat_q            <= '0;
      stat_q[ST_FROM_A] <= ~take_b_i;
      stat_q[ST_FROM_B] <= take_b_i;
    end else if (extra_i) begin
      stat_q            <= base;
      stat_q[ST_EXTRA]  <= 1'b1;
    end else begin
      stat_q <= base;
    end
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/rxsnap_hold.sv
module rxsnap_hold #(
  parameter int CNT_W = 16,
  parameter int NBUF  = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cap_i,
  input  logic [$clog2(NBUF)-1:0]   sel_i,
  input  logic [NBUF-1:0][CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0]          saved_o
);
  logic [CNT_W-1:0] pick;
  logic [CNT_W-1:0] saved_q;

  always_comb begin
    pick = '0;
    for (int i = 0; i < NBUF; i++) begin
      if (sel_i == i[$clog2(NBUF)-1:0]) pick = cnt_i[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        saved_q <= '0;
    else if (cap_i) saved_q <= pick;
  end

  assign saved_o = saved_q;
endmodule

// File: rtl/rxsnap_top.sv
module rxsnap_top
  import rxsnap_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int SYNC_STGS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel_n_i,
  input  logic             load_a_i,
  input  logic             load_b_i,
  input  logic             active_b_i,
  input  logic [CNT_W-1:0] cnt_a_i,
  input  logic [CNT_W-1:0] cnt_b_i,
  input  logic             stat_clr_i,
  output logic [CNT_W-1:0] saved_cnt_o,
  output logic [2:0]       stat_o
);
  localparam int NBUF = 2;

  logic                      sel_sync;
  logic                      desel_rise;
  logic                      armed;
  logic                      cap;
  logic                      extra;
  logic [NBUF-1:0]           loads;
  logic [NBUF-1:0][CNT_W-1:0] cnts;
  stat_t                     stat;

  assign loads   = {load_b_i, load_a_i};
  assign cnts[0] = cnt_a_i;
  assign cnts[1] = cnt_b_i;

  rxsnap_sync #(.STAGES(SYNC_STGS), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst(rst), .d_i(sel_n_i), .q_o(sel_sync), .rise_o(desel_rise)
  );

  rxsnap_arm #(.NBUF(NBUF)) u_arm (
    .clk(clk), .rst(rst), .rise_i(desel_rise), .load_i(loads),
    .armed_o(armed), .cap_o(cap), .extra_o(extra)
  );

  rxsnap_status u_stat (
    .clk(clk), .rst(rst), .cap_i(cap), .extra_i(extra),
    .take_b_i(active_b_i), .clr_i(stat_clr_i), .stat_o(stat)
  );

  rxsnap_hold #(.CNT_W(CNT_W), .NBUF(NBUF)) u_hold (
    .clk(clk), .rst(rst), .cap_i(cap), .sel_i(active_b_i),
    .cnt_i(cnts), .saved_o(saved_cnt_o)
  );

  assign stat_o = stat;
endmodule

// File: rtl/rxsnap_chk.sv
module rxsnap_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             load_a_i,
  input logic             load_b_i,
  input logic             stat_clr_i,
  input logic [CNT_W-1:0] saved_cnt_o,
  input logic [2:0]       stat_o,
  input logic             armed,
  input logic             cap,
  input logic             desel_rise
);
  // R1 / R2: snapshot moves only after a capture pulse
  a_r2_saved_only_on_cap: assert property (@(posedge clk) disable iff (rst)
    !$stable(saved_cnt_o) |-> $past(cap));

  // R2: a capture without a load disarms
  a_r2_cap_disarms: assert property (@(posedge clk) disable iff (rst)
    (cap && !load_a_i && !load_b_i) |=> !armed);

  // R5 / R8: any load leaves the capture armed
  a_r5_load_arms: assert property (@(posedge clk) disable iff (rst)
    (load_a_i || load_b_i) |=> armed);

  // R4: never both source bits
  a_r4_src_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(stat_o[1:0]));

  // R6: clear without an edge empties status
  a_r6_clear_zero: assert property (@(posedge clk) disable iff (rst)
    (stat_clr_i && !desel_rise) |=> (stat_o == 3'b000));

  // R3: unarmed edge raises extra flag
  a_r3_extra_flag: assert property (@(posedge clk) disable iff (rst)
    (desel_rise && !armed) |=> stat_o[2]);
endmodule

bind rxsnap_top rxsnap_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .load_a_i(load_a_i), .load_b_i(load_b_i),
  .stat_clr_i(stat_clr_i), .saved_cnt_o(saved_cnt_o), .stat_o(stat_o),
  .armed(armed), .cap(cap), .desel_rise(desel_rise)
);

// File: tb/rxsnap_top_tb.sv
module rxsnap_top_tb;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          sel_n = 1'b1;
  logic          load_a = 1'b0, load_b = 1'b0, act_b = 1'b0, clr = 1'b0;
  logic [CW-1:0] cnt_a = '0, cnt_b = '0;
  logic [CW-1:0] saved;
  logic [2:0]    stat;

  int n_cmp = 0, n_bad = 0;
  logic          m_armed;
  logic [CW-1:0] m_saved;
  logic [2:0]    m_stat;

  always #2 clk = ~clk;

  rxsnap_top #(.CNT_W(CW)) u_dut (
    .clk(clk), .rst(rst), .sel_n_i(sel_n), .load_a_i(load_a), .load_b_i(load_b),
    .active_b_i(act_b), .cnt_a_i(cnt_a), .cnt_b_i(cnt_b), .stat_clr_i(clr),
    .saved_cnt_o(saved), .stat_o(stat)
  );

  task automatic check(input string req);
    n_cmp++;
    if (saved !== m_saved || stat !== m_stat) begin
      n_bad++;
      $display("FAIL %s: saved=%h stat=%b expected saved=%h stat=%b",
               req, saved, stat, m_saved, m_stat);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R9 select, then R1/R2/R3 deselect
  task automatic desel(input string req);
    sel_n = 1'b0;
    cyc(4);
    check("R9 select edge no effect");
    sel_n = 1'b1;
    cyc(3);
    if (m_armed) begin
      m_saved = act_b ? cnt_b : cnt_a;
      m_stat  = {1'b0, act_b, ~act_b};
      m_armed = 1'b0;
    end else begin
      m_stat[2] = 1'b1;
    end
    check(req);
  endtask

  task automatic load(input logic which_b);
    if (which_b) load_b = 1'b1; else load_a = 1'b1;
    cyc(1);
    load_a = 1'b0; load_b = 1'b0;
    cyc(1);
    m_armed = 1'b1;
    check("R5 load leaves outputs");
  endtask

  task automatic clear();
    clr = 1'b1;
    cyc(1);
    clr = 1'b0;
    cyc(1);
    m_stat = '0;
    check("R6 clear zeroes status");
  endtask

  initial begin
    m_armed = 1'b0; m_saved = '0; m_stat = '0;
    cyc(3);
    rst = 1'b0;
    cyc(1);
    check("R7 reset state");
    cnt_a = 16'h1234; cnt_b = 16'h5678;
    desel("R7 edge before load sets only extra");
    clear();

    // sweep: active buffer, loaded buffer, number of deselect edges
    for (int ab = 0; ab < 2; ab++) begin
      for (int lb = 0; lb < 2; lb++) begin
        for (int ne = 1; ne <= 3; ne++) begin
          cnt_a = CW'(16'h0100 * (ab + 2*lb + 1) + ne * 37);
          cnt_b = CW'(16'hF000 - 16'h0100 * (lb + 1) - ne * 11);
          act_b = ab[0];
          load(lb[0]);
          desel("R1 R4 capture of active count");
          cnt_a = cnt_a + 16'd5; cnt_b = cnt_b + 16'd9;
          for (int e = 1; e < ne; e++) desel("R2 R3 later edge keeps snapshot");
          if (ne == 3) clear();
        end
      end
    end

    // R8: load lands on the capture edge
    cnt_a = 16'hAAAA; cnt_b = 16'h5555; act_b = 1'b0;
    load(1'b0);
    sel_n = 1'b0; cyc(4);
    sel_n = 1'b1; cyc(2);
    load_b = 1'b1; cyc(1); load_b = 1'b0;
    m_saved = 16'hAAAA; m_stat = 3'b001; m_armed = 1'b1;
    check("R8 capture with coincident load");
    act_b = 1'b1; cnt_b = 16'h7777;
    desel("R8 stays armed after coincident load");

    // R6: clear leaves snapshot, then a capture reports fresh status
    clear();
    load(1'b1);
    act_b = 1'b0; cnt_a = 16'h0042;
    desel("R4 capture clears extra bit");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: timeout actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule